// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is one input-capture channel of a timer. A pin that is not synchronous to the kernel clock passes through a synchronizer and then a digital glitch filter. The filter takes samples of the input at a rate chosen by a 4-bit filter code. It hands a new level to its output only after a run of identical samples at that level. The code sets both the sample spacing and the run length, from a fixed table that is not uniform.

The filtered level goes through an edge selector. The chosen edges feed an event prescaler. Each event that the prescaler lets through copies a free-running timebase into the capture register and raises a capture flag. When a capture arrives while the flag is still set, an overcapture flag is raised. The channel role is held in a small register that can only be changed while the channel is disabled. Disabling the channel returns the prescaler to its first event.

Top module: `icap_channel`

## Requirements
- R1: The role register (`role_q`) is 2'd0 after reset. Role 2'd1 means input capture. Any other role value (2'd0 means output) produces no capture.
- R2: A pulse on `role_wr` loads `role_wdata` into the role register only while `chan_en` is 0. While `chan_en` is 1 the write is ignored.
- R3: The prescaler code `psc_sel` gives the ratio: 0 is 1, 1 is 2, 2 is 4 and 3 is 8. Counting from enable, a capture happens on qualifying edges ratio, 2*ratio, and so on.
- R4: While `chan_en` is 0 the prescaler event count is held at zero. After re-enabling, the first capture comes on the ratio-th new qualifying edge.
- R5: The filter changes its output only after N consecutive samples at the new level. A sample equal to the current output restarts the run. A pulse that covers at most (N-1)*D clock cycles is rejected, where D is the sample spacing in clocks.
- R6: Filter code to (D, N), with D counted in `dts_en` pulses. Codes 1 to 3 instead sample every kernel clock with N = 2, 4 and 8. Code 0 gives (1,1). Codes 4 and 5 give D=2 with N = 6 and 8. Codes 6 and 7 give D=4 with N = 6 and 8. Codes 8 and 9 give D=8 with N = 6 and 8. Codes 10, 11 and 12 give D=16 with N = 5, 6 and 8. Codes 13, 14 and 15 give D=32 with N = 5, 6 and 8.
- R7: Hold `dts_en` at 1 and let the pin change before the clock edge at which `timebase` = k. The captured value is then k+3+(N-1)*D+p. Here p = 0 for codes 0 to 3, and 0 <= p <= D-1 for the other codes.
- R8: `edge_pol` chooses the capture edge of the filtered signal: 0 is rising, 1 is falling, and 2 or 3 is both.
- R9: A capture loads `timebase` into `cap_val` and sets `cap_flag`. A `flag_clr` pulse clears `cap_flag` and `ovr_flag`, unless a capture happens in the same cycle, in which case the capture takes precedence.
- R10: A capture that happens while `cap_flag` is already set, and `flag_clr` is not active, sets `ovr_flag`.
- R11: A change of `flt_sel` clears the filter run count and the sample divider on that edge, without taking a sample. The filtered level keeps its last confirmed value.
- R12: During reset, `cap_val` is 0, both flags are 0, and the filtered level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dts_en | input | 1 | One-cycle enable at the DTS rate |
| pin_in | input | 1 | Asynchronous capture input |
| role_wr | input | 1 | Write strobe for the role register |
| role_wdata | input | 2 | Role value to write |
| chan_en | input | 1 | Channel enable |
| psc_sel | input | PSC_W | Event prescaler code |
| flt_sel | input | 4 | Filter code |
| edge_pol | input | 2 | Capture edge selection |
| timebase | input | TB_W | Free-running counter value |
| flag_clr | input | 1 | Clear pulse for both flags |
| role_q | output | 2 | Stored channel role |
| cap_val | output | TB_W | Captured timebase value |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |

## Verification
The assertions assume three things about the inputs. `timebase` advances freely. Reset is held low across the first clock edge. The configuration inputs change only between clock edges. The bench drives every input, including the pin, on the falling clock edge, and keeps `dts_en` high while it checks latency. Because of that, the sample phase of the divided filter codes is the only uncertainty, and the bench bounds it with a window one period wide. Glitch pulses are sized from the table values (D, N), so a pulse at the rejection limit can never reach N samples. Each prescaler run begins from a disable and enable pair, so the expected count starts at zero.

// File: rtl/icap_pkg.sv
package icap_pkg;

   localparam int unsigned FLT_CODE_W = 4;
   localparam int unsigned FLT_MAX_DIV = 32;
   localparam int unsigned FLT_MAX_LEN = 8;
   localparam int unsigned FLT_DIV_W = $clog2(FLT_MAX_DIV);
   localparam int unsigned FLT_LEN_W = $clog2(FLT_MAX_LEN + 1);

   typedef enum logic [1:0] {
      ROLE_OUT = 2'd0,
      ROLE_IN  = 2'd1
   } role_e;

   typedef enum logic [1:0] {
      POL_RISE = 2'd0,
      POL_FALL = 2'd1,
      POL_BOTH = 2'd2
   } pol_e;

   // Sample spacing, counted in DTS enable pulses
   function automatic int unsigned flt_div(input logic [FLT_CODE_W-1:0] c);
      int unsigned d;
      case (c)
         4'd4, 4'd5:        d = 2;
         4'd6, 4'd7:        d = 4;
         4'd8, 4'd9:        d = 8;
         4'd10, 4'd11, 4'd12: d = 16;
         4'd13, 4'd14, 4'd15: d = 32;
         default:           d = 1;
      endcase
      return d;
   endfunction

   // Run length needed to confirm a level change
   function automatic int unsigned flt_len(input logic [FLT_CODE_W-1:0] c);
      int unsigned n;
      case (c)
         4'd0:                       n = 1;
         4'd1:                       n = 2;
         4'd2:                       n = 4;
         4'd10, 4'd13:               n = 5;
         4'd4, 4'd6, 4'd8, 4'd11, 4'd14: n = 6;
         default:                    n = 8;
      endcase
      return n;
   endfunction

   // Codes that sample on every kernel clock
   function automatic logic flt_kernel(input logic [FLT_CODE_W-1:0] c);
      return (c == 4'd1) || (c == 4'd2) || (c == 4'd3);
   endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("icap_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d};
   end

   assign q = sh_q[STAGES-1];

endmodule

// File: rtl/icap_filter.sv
module icap_filter
   import icap_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dts_en,
   input  logic [FLT_CODE_W-1:0] code,
   input  logic                  din,
   output logic                  dout
);

   localparam int unsigned DIV_W = FLT_DIV_W;
   localparam int unsigned LEN_W = FLT_LEN_W;

   generate
      if (DIV_W < 1 || LEN_W < 1) begin : g_bad_widths
         $error("icap_filter: derived widths must be positive");
      end
   endgenerate

   logic [FLT_CODE_W-1:0] code_q;
   logic [DIV_W-1:0]      div_q;
   logic [LEN_W-1:0]      run_q;
   logic                  lvl_q;
   logic [DIV_W-1:0]      div_lim;
   logic [LEN_W-1:0]      run_len;
   logic                  kern;
   logic                  code_chg;
   logic                  smp_en;
   logic [LEN_W-1:0]      run_nx;

   assign code_chg = (code != code_q);
   assign div_lim  = DIV_W'(flt_div(code_q) - 1);
   assign run_len  = LEN_W'(flt_len(code_q));
   assign kern     = flt_kernel(code_q);
   assign smp_en   = !code_chg && (kern || (dts_en && (div_q == div_lim)));
   assign run_nx   = run_q + LEN_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         div_q  <= '0;
         run_q  <= '0;
         lvl_q  <= 1'b0;
      end else if (code_chg) begin
         code_q <= code;
         div_q  <= '0;
         run_q  <= '0;
      end else begin
         if (dts_en && !kern)
            div_q <= (div_q == div_lim) ? '0 : div_q + DIV_W'(1);
         if (smp_en) begin
            if (din == lvl_q) begin
               run_q <= '0;
            end else if (run_nx == run_len) begin
               lvl_q <= din;
               run_q <= '0;
            end else begin
               run_q <= run_nx;
            end
         end
      end
   end

   assign dout = lvl_q;

   // R5: the confirmed level moves only on a sampling edge
   a_r5_move_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> $past(smp_en));

   // R11: a code change restarts the run and keeps the level
   a_r11_code_restart: assert property (@(posedge clk) disable iff (!rst_n)
      code_chg |=> (run_q == '0) && (div_q == '0) && $stable(lvl_q));

endmodule

// File: rtl/icap_prescaler.sv
module icap_prescaler #(
   parameter int unsigned SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ev,
   input  logic [SEL_W-1:0] sel,
   output logic             fire
);

   localparam int unsigned CNT_W = (1 << SEL_W) - 1;

   generate
      if (SEL_W < 1 || SEL_W > 3) begin : g_bad_sel
         $error("icap_prescaler: SEL_W must be 1..3");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask;

   assign mask = CNT_W'((32'd1 << sel) - 32'd1);
   assign fire = ev && ((cnt_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (fire)   cnt_q <= '0;
      else if (ev)     cnt_q <= cnt_q + CNT_W'(1);
   end

   // R4: the count is empty on the edge after a disable
   a_r4_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

   // R3: the count never passes the selected ratio
   a_r3_within_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q & ~mask) == '0 || $past(sel) != sel);

endmodule

// File: rtl/icap_channel.sv
module icap_channel
   import icap_pkg::*;
#(
   parameter int unsigned TB_W        = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PSC_W       = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dts_en,
   input  logic                  pin_in,
   input  logic                  role_wr,
   input  logic [1:0]            role_wdata,
   input  logic                  chan_en,
   input  logic [PSC_W-1:0]      psc_sel,
   input  logic [FLT_CODE_W-1:0] flt_sel,
   input  logic [1:0]            edge_pol,
   input  logic [TB_W-1:0]       timebase,
   input  logic                  flag_clr,
   output logic [1:0]            role_q,
   output logic [TB_W-1:0]       cap_val,
   output logic                  cap_flag,
   output logic                  ovr_flag
);

   generate
      if (TB_W < 2) begin : g_bad_tb
         $error("icap_channel: TB_W must be at least 2");
      end
   endgenerate

   logic pin_s;
   logic lvl;
   logic lvl_d;
   logic rise;
   logic fall;
   logic edge_hit;
   logic ev;
   logic fire;

   icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

   icap_filter u_filt (
      .clk(clk), .rst_n(rst_n), .dts_en(dts_en),
      .code(flt_sel), .din(pin_s), .dout(lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    role_q <= ROLE_OUT;
      else if (role_wr && !chan_en)  role_q <= role_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign rise = lvl && !lvl_d;
   assign fall = !lvl && lvl_d;

   always_comb begin
      case (edge_pol)
         POL_RISE: edge_hit = rise;
         POL_FALL: edge_hit = fall;
         default:  edge_hit = rise || fall;
      endcase
   end

   assign ev = chan_en && (role_q == ROLE_IN) && edge_hit;

   icap_prescaler #(.SEL_W(PSC_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .clr(!chan_en),
      .ev(ev), .sel(psc_sel), .fire(fire));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val  <= '0;
         cap_flag <= 1'b0;
         ovr_flag <= 1'b0;
      end else if (fire) begin
         cap_val  <= timebase;
         cap_flag <= 1'b1;
         ovr_flag <= ovr_flag || (cap_flag && !flag_clr);
      end else if (flag_clr) begin
         cap_flag <= 1'b0;
         ovr_flag <= 1'b0;
      end
   end

   // R2: the role stays put while the channel is on
   a_r2_role_locked: assert property (@(posedge clk) disable iff (!rst_n)
      chan_en |=> $stable(role_q));

   // R1: no capture unless the role selects input capture
   a_r1_role_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (role_q != ROLE_IN) |=> $stable(cap_val) || $past(flag_clr) || !$past(role_q != ROLE_IN));

   // R9: a capture stores the timebase and sets the flag
   a_r9_capture_store: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> cap_flag && (cap_val == $past(timebase)));

   // R10: a capture onto a set flag raises overcapture
   a_r10_overcapture: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && cap_flag && !flag_clr) |=> ovr_flag);

endmodule

// File: tb/icap_channel_tb.sv
module icap_channel_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dts_en = 1'b1;
   logic        pin_in = 1'b0;
   logic        role_wr = 1'b0;
   logic [1:0]  role_wdata = 2'd0;
   logic        chan_en = 1'b0;
   logic [1:0]  psc_sel = 2'd0;
   logic [3:0]  flt_sel = 4'd0;
   logic [1:0]  edge_pol = 2'd2;
   logic [15:0] timebase = 16'd0;
   logic        flag_clr = 1'b0;
   logic [1:0]  role_q;
   logic [15:0] cap_val;
   logic        cap_flag;
   logic        ovr_flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   always_ff @(posedge clk) timebase <= timebase + 16'd1;

   icap_channel u_dut (
      .clk(clk), .rst_n(rst_n), .dts_en(dts_en), .pin_in(pin_in),
      .role_wr(role_wr), .role_wdata(role_wdata), .chan_en(chan_en),
      .psc_sel(psc_sel), .flt_sel(flt_sel), .edge_pol(edge_pol),
      .timebase(timebase), .flag_clr(flag_clr), .role_q(role_q),
      .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag));

   function automatic int tdiv(input int c);
      if (c >= 13) return 32;
      if (c >= 10) return 16;
      if (c >= 8)  return 8;
      if (c >= 6)  return 4;
      if (c >= 4)  return 2;
      return 1;
   endfunction

   function automatic int tlen(input int c);
      case (c)
         0: return 1;
         1: return 2;
         2: return 4;
         10, 13: return 5;
         4, 6, 8, 11, 14: return 6;
         default: return 8;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic clear_flags();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic wait_cap(input int lim, output bit found, output int val);
      found = 1'b0;
      val = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (cap_flag) begin
            found = 1'b1;
            val = int'(cap_val);
            break;
         end
      end
   endtask

   task automatic pulse(input int hi, input int lo);
      pin_in = 1'b1;
      cyc(hi);
      pin_in = 1'b0;
      cyc(lo);
   endtask

   task automatic reenable();
      chan_en = 1'b0;
      cyc(2);
      chan_en = 1'b1;
      cyc(1);
   endtask

   initial begin
      bit found;
      int val;
      int k;
      int lo;
      int hi;

      cyc(4);
      // R12 reset state
      chk(cap_val == 16'd0, "R12 cap_val in reset", int'(cap_val), 0);
      chk(!cap_flag && !ovr_flag, "R12 flags in reset", int'({cap_flag, ovr_flag}), 0);
      chk(role_q == 2'd0, "R1 role after reset", int'(role_q), 0);
      rst_n = 1'b1;
      cyc(2);

      // R2 write while disabled takes effect
      role_wdata = 2'd1; role_wr = 1'b1;
      cyc(1);
      role_wr = 1'b0;
      chk(role_q == 2'd1, "R2 write while disabled", int'(role_q), 1);
      chan_en = 1'b1;
      cyc(1);
      role_wdata = 2'd0; role_wr = 1'b1;
      cyc(1);
      role_wr = 1'b0;
      cyc(1);
      chk(role_q == 2'd1, "R2 write while enabled ignored", int'(role_q), 1);

      // R6/R7 latency sweep over every filter code, both edges
      edge_pol = 2'd2;
      psc_sel = 2'd0;
      for (int c = 0; c < 16; c++) begin
         flt_sel = 4'(c);
         cyc(3);
         for (int lv = 1; lv >= 0; lv--) begin
            pin_in = 1'(lv);
            k = int'(timebase);
            wait_cap(1000, found, val);
            lo = k + 3 + (tlen(c) - 1) * tdiv(c);
            hi = (c < 4) ? lo : lo + tdiv(c) - 1;
            chk(found, $sformatf("R6 capture seen code %0d", c), int'(found), 1);
            chk(val >= lo && val <= hi, $sformatf("R7 latency code %0d", c), val, lo);
            cyc(2);
            clear_flags();
         end
      end

      // R5 glitch one sample short of the run is rejected
      for (int c = 1; c < 16; c++) begin
         flt_sel = 4'(c);
         cyc(3);
         pulse((tlen(c) - 1) * tdiv(c), tlen(c) * tdiv(c) + 20);
         chk(!cap_flag, $sformatf("R5 glitch rejected code %0d", c), int'(cap_flag), 0);
         clear_flags();
      end

      // R8 edge polarity
      flt_sel = 4'd1;
      cyc(3);
      for (int p = 0; p < 2; p++) begin
         edge_pol = 2'(p);
         pin_in = 1'b1;
         cyc(12);
         chk(cap_flag == (p == 0), $sformatf("R8 rise pol %0d", p), int'(cap_flag), int'(p == 0));
         clear_flags();
         pin_in = 1'b0;
         cyc(12);
         chk(cap_flag == (p == 1), $sformatf("R8 fall pol %0d", p), int'(cap_flag), int'(p == 1));
         clear_flags();
      end

      // R3 prescaler ratios, rising edges
      edge_pol = 2'd0;
      for (int p = 0; p < 4; p++) begin
         psc_sel = 2'(p);
         reenable();
         for (int e = 1; e <= 16; e++) begin
            pulse(6, 10);
            chk(cap_flag == ((e % (1 << p)) == 0),
                $sformatf("R3 psc %0d edge %0d", p, e), int'(cap_flag), int'((e % (1 << p)) == 0));
            clear_flags();
         end
      end

      // R4 disable clears the prescaler count
      psc_sel = 2'd2;
      reenable();
      pulse(6, 10);
      reenable();
      for (int e = 1; e <= 4; e++) begin
         pulse(6, 10);
         chk(cap_flag == (e == 4), $sformatf("R4 after re-enable edge %0d", e), int'(cap_flag), int'(e == 4));
         clear_flags();
      end

      // R1 output role and undefined role capture nothing
      psc_sel = 2'd0;
      for (int r = 0; r < 4; r += 2) begin
         chan_en = 1'b0;
         role_wdata = 2'(r); role_wr = 1'b1;
         cyc(1);
         role_wr = 1'b0;
         chan_en = 1'b1;
         cyc(1);
         pulse(6, 10);
         chk(!cap_flag, $sformatf("R1 no capture role %0d", r), int'(cap_flag), 0);
      end
      chan_en = 1'b0;
      role_wdata = 2'd1; role_wr = 1'b1;
      cyc(1);
      role_wr = 1'b0;
      chan_en = 1'b1;
      cyc(1);

      // R9 exact value, R10 overcapture, clear
      pin_in = 1'b1;
      k = int'(timebase);
      cyc(6);
      pin_in = 1'b0;
      cyc(10);
      chk(cap_flag && int'(cap_val) == k + 4, "R9 capture value", int'(cap_val), k + 4);
      chk(!ovr_flag, "R10 no overcapture yet", int'(ovr_flag), 0);
      pin_in = 1'b1;
      k = int'(timebase);
      cyc(6);
      pin_in = 1'b0;
      cyc(10);
      chk(int'(cap_val) == k + 4, "R9 second capture value", int'(cap_val), k + 4);
      chk(ovr_flag, "R10 overcapture set", int'(ovr_flag), 1);
      clear_flags();
      chk(!cap_flag && !ovr_flag, "R9 clear pulse", int'({cap_flag, ovr_flag}), 0);

      // R11 code change mid-run restarts count, keeps level
      edge_pol = 2'd2;
      flt_sel = 4'd3;
      cyc(3);
      pin_in = 1'b1;
      cyc(20);
      clear_flags();
      flt_sel = 4'd2;
      cyc(3);
      pin_in = 1'b0;
      k = int'(timebase);
      cyc(4);
      flt_sel = 4'd3;
      wait_cap(100, found, val);
      chk(found && val == k + 13, "R11 restart after code change", val, k + 13);
      clear_flags();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule